// File: doc/BRIEF.md
# Sliding Least-Squares Tone Demodulator

This block recovers the in-phase and quadrature parts of a tone sampled at a ratio other than four samples per period. The sampling rate is chosen so that the tone frequency divided by the sample rate equals M/N, with M and N integers. Between two consecutive samples the tone's phase therefore advances by 2π·M/N. The whole N-sample cycle visits every phase slot 2πk/N once, provided M and N share no common factor.

A fixed offset is subtracted from each accepted sample. The result is multiplied by a cosine weight and by a sine weight taken from tables built at elaboration, at the slot of the current phase. Each product stream passes through a running N-sample sum, which adds the newest product and removes the one from N samples earlier. After the window first fills, a new I/Q pair appears one clock after every accepted sample.

The window acts as an N-tap moving average. Harmonics whose order is not congruent to ±1 modulo N cancel out, which covers every order from 2 to N−2. With N=7 and M=26 (a 1.3 GHz tone sampled at 350 MSa/s), harmonics 2 to 5 are rejected. With N=24 and M=79 (sampled near 394.94 MSa/s), harmonics 2 to 22 are rejected.

Top module: `lsq_demod`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: The phase slot is 0 for the first sample accepted after reset and moves forward by M modulo N for each later accepted sample. Sample number n (counting from 0) therefore uses slot (n·M) mod N.
- R3: `out_i` equals floor(S_I / 2^(CW−1)), where S_I is the sum over the last N accepted samples of (sample − OFFSET)·WC[k]. Here k is the sample's slot and WC[k] = round((2/N)·(2^(CW−1)−1)·cos(2πk/N)).
- R4: `out_q` follows the same rule with WS[k] = round((2/N)·(2^(CW−1)−1)·sin(2πk/N)).
- R5: `out_valid` is high for exactly one clock after each accepted sample, starting with the N-th sample since reset, and is low at all other times.
- R6: A clock with `in_valid` low leaves `out_i`, `out_q` and the phase slot unchanged, and `out_valid` is low on the next clock.
- R7: An input of A·cos(h·2πnM/N) + OFFSET, with harmonic order h in {2, 3} and A up to 6000, gives |`out_i`| and |`out_q`| of at most 4 once the window is full.
- R8: An input of A·cos(2πnM/N − φ) + OFFSET gives `out_i` within 4 of A·cos φ and `out_q` within 4 of A·sin φ once the window is full.
- R9: Full-scale input whose sign matches the weight at every slot gives the exact result of R3 and R4, so the accumulators do not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_sample` as a sample to accept on this edge |
| in_sample | input | DW | Signed two's-complement ADC sample |
| out_valid | output | 1 | Marks a fresh I/Q estimate |
| out_i | output | DW+$clog2(N)+3 | Signed in-phase estimate |
| out_q | output | DW+$clog2(N)+3 | Signed quadrature estimate |

## Verification
The state that is hardest to reach from the ports is the wrap of the sliding window. Here the product being subtracted belongs to an earlier slot than the one being added, and gaps in `in_valid` must not shift the slot order. The stimulus table therefore runs well past N samples, with idle clocks inserted at irregular points. A bench model tracks the slot of every accepted sample and checks each output exactly. A full-scale pattern then drives the accumulators to their largest magnitude, and synthesized fundamental and harmonic tones confirm the estimator's meaning, not just its arithmetic.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Weight for phase slot k, with the 2/N least-squares scale folded in.
  function automatic int lsq_weight(int k, int n, int cw, bit use_sin);
    real ang;
    real mag;
    real v;
    ang = TWO_PI * real'(k) / real'(n);
    mag = 2.0 * real'((1 << (cw - 1)) - 1) / real'(n);
    v   = use_sin ? mag * $sin(ang) : mag * $cos(ang);
    return $rtoi($floor(v + 0.5));
  endfunction

endpackage

// File: rtl/lsq_phase_gen.sv
module lsq_phase_gen #(
  parameter int N = 7,
  parameter int M = 26,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [IW-1:0] phase
);
  localparam int STEP = M % N;

  logic [IW:0]   phase_sum;
  logic [IW-1:0] phase_next;

  assign phase_sum  = {1'b0, phase} + (IW+1)'(STEP);
  assign phase_next = (phase_sum >= (IW+1)'(N)) ? IW'(phase_sum - (IW+1)'(N))
                                                 : phase_sum[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (advance) phase <= phase_next;
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < N);

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> int'(phase) == (int'($past(phase)) + M) % N);

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(phase));

endmodule

// File: rtl/lsq_coef_rom.sv
module lsq_coef_rom #(
  parameter int N  = 7,
  parameter int CW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0]        phase,
  output logic signed [CW-1:0] w_cos,
  output logic signed [CW-1:0] w_sin
);
  import lsq_pkg::*;

  localparam int SLOTS = 1 << IW;

  logic signed [CW-1:0] cos_tab [SLOTS];
  logic signed [CW-1:0] sin_tab [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < N) begin : g_used
      localparam int WC = lsq_weight(k, N, CW, 1'b0);
      localparam int WS = lsq_weight(k, N, CW, 1'b1);
      assign cos_tab[k] = CW'(WC);
      assign sin_tab[k] = CW'(WS);
    end else begin : g_spare
      assign cos_tab[k] = '0;
      assign sin_tab[k] = '0;
    end
  end

  assign w_cos = cos_tab[phase];
  assign w_sin = sin_tab[phase];

endmodule

// File: rtl/lsq_window_acc.sv
module lsq_window_acc #(
  parameter int N  = 7,
  parameter int PW = 31,
  parameter int AW = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [PW-1:0] prod,
  output logic signed [AW-1:0] acc
);
  logic signed [PW-1:0] line [N];
  logic signed [PW-1:0] oldest;

  assign oldest = line[N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) line[i] <= '0;
      acc <= '0;
    end else if (push) begin
      line[0] <= prod;
      for (int i = 1; i < N; i++) line[i] <= line[i-1];
      acc <= acc + AW'(prod) - AW'(oldest);
    end
  end

  localparam logic signed [AW-1:0] BOUND = AW'(N) <<< (PW - 1);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc <= BOUND) && (acc >= -BOUND));

endmodule

// File: rtl/lsq_demod.sv
module lsq_demod #(
  parameter int N      = 7,
  parameter int M      = 26,
  parameter int DW     = 14,
  parameter int CW     = 16,
  parameter int OFFSET = 12,
  localparam int IW = $clog2(N),
  localparam int XW = DW + 1,
  localparam int PW = XW + CW,
  localparam int AW = PW + IW + 1,
  localparam int OW = AW - CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);
  logic [IW-1:0]        phase;
  logic signed [CW-1:0] w_cos;
  logic signed [CW-1:0] w_sin;
  logic signed [XW-1:0] x_corr;
  logic signed [PW-1:0] prod_i;
  logic signed [PW-1:0] prod_q;
  logic signed [AW-1:0] acc_i;
  logic signed [AW-1:0] acc_q;
  logic [IW-1:0]        fill;
  logic                 window_full;
  logic                 last_fill;

  lsq_phase_gen #(.N(N), .M(M)) u_phase (
    .clk(clk), .rst_n(rst_n), .advance(in_valid), .phase(phase));

  lsq_coef_rom #(.N(N), .CW(CW)) u_rom (
    .phase(phase), .w_cos(w_cos), .w_sin(w_sin));

  assign x_corr = XW'(in_sample) - XW'(OFFSET);
  assign prod_i = x_corr * w_cos;
  assign prod_q = x_corr * w_sin;

  lsq_window_acc #(.N(N), .PW(PW), .AW(AW)) u_acc_i (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .prod(prod_i), .acc(acc_i));

  lsq_window_acc #(.N(N), .PW(PW), .AW(AW)) u_acc_q (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .prod(prod_q), .acc(acc_q));

  assign last_fill = (fill == IW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill        <= '0;
      window_full <= 1'b0;
      out_valid   <= 1'b0;
    end else begin
      out_valid <= in_valid && (window_full || last_fill);
      if (in_valid && !window_full) begin
        if (last_fill) window_full <= 1'b1;
        else           fill        <= fill + 1'b1;
      end
    end
  end

  assign out_i = acc_i[AW-1:CW-1];
  assign out_q = acc_q[AW-1:CW-1];

  assert_valid_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> window_full);

  assert_valid_follows_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_first_fill_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_full) |-> out_valid);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_i) && $stable(acc_q) && !out_valid));

endmodule

// File: tb/tb_lsq_demod.sv
module tb_lsq_demod;
  localparam int N      = 7;
  localparam int M      = 26;
  localparam int DW     = 14;
  localparam int CW     = 16;
  localparam int OFFSET = 12;
  localparam int OW     = DW + $clog2(N) + 3;
  localparam real PI    = 3.14159265358979;

  localparam int NVEC = 24;
  localparam int VEC [NVEC] = '{
    100, -200, 3000, -4000, 8191, -8192, 0, 12, 77, -1, 5000, -5000,
    1234, -4321, 2, 8000, -7999, 600, 600, 600, -3, 4096, -4096, 31};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic out_valid;
  logic signed [OW-1:0] out_i;
  logic signed [OW-1:0] out_q;

  lsq_demod #(.N(N), .M(M), .DW(DW), .CW(CW), .OFFSET(OFFSET)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  longint hx [N];
  int hk [N];
  int cnt = 0;
  int slot = 0;

  function automatic longint wgt(int k, bit s);
    real a;
    a = 2.0 * PI * k / N;
    return longint'(int'((65534.0 / N) * (s ? $sin(a) : $cos(a))));
  endfunction

  function automatic longint model_out(bit s);
    longint acc = 0;
    for (int i = 0; i < N; i++) if (i < cnt) acc += hx[i] * wgt(hk[i], s);
    return acc >>> (CW - 1);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_near(string tag, longint act, longint exp, longint tol);
    n_checks++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d+-%0d", tag, act, exp, tol);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    cnt = 0;
    slot = 0;
    for (int i = 0; i < N; i++) begin hx[i] = 0; hk[i] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(int x, bit exact);
    in_valid = 1'b1;
    in_sample = DW'(x);
    @(negedge clk);
    for (int i = N - 1; i > 0; i--) begin hx[i] = hx[i-1]; hk[i] = hk[i-1]; end
    hx[0] = longint'(x - OFFSET);
    hk[0] = slot;
    slot = (slot + M) % N;
    cnt++;
    check("R5 out_valid after sample", longint'(out_valid), longint'(cnt >= N));
    if (exact && cnt >= N) begin
      check("R3 out_i (R2 slot order)", longint'(out_i), model_out(1'b0));
      check("R4 out_q (R2 slot order)", longint'(out_q), model_out(1'b1));
    end
  endtask

  task automatic idle();
    longint pi_v, pq_v;
    pi_v = longint'(out_i);
    pq_v = longint'(out_q);
    in_valid = 1'b0;
    @(negedge clk);
    check("R6 out_valid low on idle", longint'(out_valid), 0);
    check("R6 out_i held", longint'(out_i), pi_v);
    check("R6 out_q held", longint'(out_q), pq_v);
  endtask

  task automatic tone(int h, real amp, real phi);
    int x;
    do_reset();
    for (int n = 0; n < 3 * N; n++) begin
      x = int'(amp * $cos(h * 2.0 * PI * n * M / N - phi)) + OFFSET;
      push(x, 1'b1);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 out_i in reset", longint'(out_i), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_q after reset", longint'(out_q), 0);

    // Table walk with irregular idle gaps: R2, R3, R4, R5, R6
    do_reset();
    for (int v = 0; v < NVEC; v++) begin
      push(VEC[v], 1'b1);
      if (v % 5 == 3) idle();
    end
    idle();

    // Mid-stream reset restarts the fill count (R5) and slot order (R2)
    push(999, 1'b1);
    do_reset();
    check("R1 out_i after second reset", longint'(out_i), 0);
    for (int v = 0; v < N + 3; v++) push(VEC[NVEC - 1 - v], 1'b1);

    // R9: full-scale input matching weight signs
    do_reset();
    for (int n = 0; n < 2 * N; n++) begin
      int k;
      k = (n * M) % N;
      push((wgt(k, 1'b0) >= 0) ? 8191 : -8192, 1'b1);
    end
    do_reset();
    for (int n = 0; n < 2 * N; n++) begin
      int k;
      k = (n * M) % N;
      push((wgt(k, 1'b1) >= 0) ? 8191 : -8192, 1'b1);
    end

    // R8: fundamental tone at two phases
    tone(1, 6000.0, PI / 3.0);
    check_near("R8 I of fundamental", longint'(out_i), longint'(int'(6000.0 * $cos(PI / 3.0))), 4);
    check_near("R8 Q of fundamental", longint'(out_q), longint'(int'(6000.0 * $sin(PI / 3.0))), 4);
    tone(1, 4000.0, -2.0);
    check_near("R8 I of fundamental", longint'(out_i), longint'(int'(4000.0 * $cos(-2.0))), 4);
    check_near("R8 Q of fundamental", longint'(out_q), longint'(int'(4000.0 * $sin(-2.0))), 4);

    // R7: harmonic rejection
    tone(2, 6000.0, 0.0);
    check_near("R7 I of 2nd harmonic", longint'(out_i), 0, 4);
    check_near("R7 Q of 2nd harmonic", longint'(out_q), 0, 4);
    tone(3, 6000.0, 0.7);
    check_near("R7 I of 3rd harmonic", longint'(out_i), 0, 4);
    check_near("R7 Q of 3rd harmonic", longint'(out_q), 0, 4);

    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule